// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider Controller

This block is the programmable feedback divider of a frequency synthesizer loop. It is used with an external two-modulus prescaler. The prescaler's output is the block's only clock, `clk_fin`. On each rising edge of that clock, two down-counters step together. The N counter sets the length of one divide cycle in prescaler output periods. The A counter sets how many of those periods run with the prescaler on its larger modulus. The block drives the prescaler's modulus-select line, `mod_ctl`. It also gives one divided pulse per cycle, `div_out`, which the phase comparator uses.

`mod_ctl` is low at the start of each cycle, so the prescaler divides by P+1. It stays low while the A counter runs down. It then goes high, so the prescaler divides by P, for the remaining N − A periods. From the oscillator to `div_out`, the total division is N·P + A. N and A are taken from the input ports only at the reload edge that starts a cycle. A value written in the middle of a cycle therefore waits for the next cycle boundary. The reset input is asynchronous and active low. Its release is synchronised to `clk_fin` through `SYNC_STAGES` flops.

Top module: `dmp_divider_ctl`

## Requirements
- R1: While reset is asserted, and after release until the first reload, `mod_ctl` and `div_out` are both low. The first `clk_fin` edge after the internal synchronised reset releases is a reload edge.
- R2: After a reload edge, `mod_ctl` is low for the first min(A, N) input periods of the cycle. With A = 0 it is high from the first period.
- R3: Once the A count is used up, `mod_ctl` stays high until the cycle ends. With A ≥ N it stays low for the whole cycle.
- R4: A cycle is exactly N `clk_fin` periods long. `div_out` is high during the last period only. The edge that ends that period reloads both counters.
- R5: With a prescaler dividing by P+1 while `mod_ctl` is low and by P while it is high, each cycle spans N·P + A oscillator periods when A ≤ N.
- R6: Changes on `n_val` or `a_val` during a cycle have no effect on that cycle. The values present at the reload edge govern the whole next cycle.
- R7: The full legal range works: N from 16 to 1023 and A from 0 to 127. This includes N = 1023 with A = 127, and N = 16 with A = 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fin | input | 1 | Prescaler output; rising edges are counted |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | N_W (10) | Programmed N: cycle length in input periods |
| a_val | input | A_W (7) | Programmed A: periods at the larger prescaler modulus |
| mod_ctl | output | 1 | Modulus select: low = P+1, high = P |
| div_out | output | 1 | High for the last input period of each cycle |

## Verification
The bench drives the block through a behavioural P/P+1 prescaler. It counts oscillator periods per cycle. A design that reloaded one edge early or late would show up as a span off by P or P+1. The A = 0 case catches a modulus line that waits one period before going high. A = N, and A above N, catch a design that lets the A counter wrap and raises `mod_ctl` in the wrong place. The bench writes random values into N and A in the middle of each cycle. A design that loads them at once, rather than at the reload edge, would break the cycle length and the modulus pattern of the cycle in progress.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  // Modulus phase of the divide cycle
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // after reset, before the first reload
    PH_LOW  = 2'd1,  // A counter still running: prescaler at P+1
    PH_HIGH = 2'd2   // A counter spent: prescaler at P
  } phase_e;
endpackage

// File: rtl/dmp_rst_sync.sv
module dmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/dmp_down_cnt.sv
module dmp_down_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  // Load wins; otherwise step down when enabled, holding at zero
  always_comb begin
    cnt_nxt = cnt;
    if (load)                  cnt_nxt = load_val;
    else if (en && cnt != '0)  cnt_nxt = cnt - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R6: without a load the count only steps down by one, whatever the load value does
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  // R3: an exhausted count stays at zero until reloaded
  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/dmp_divider_ctl.sv
module dmp_divider_ctl #(
  parameter int N_W         = 10,
  parameter int A_W         = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_fin,
  input  logic           rst_n,
  input  logic [N_W-1:0] n_val,
  input  logic [A_W-1:0] a_val,
  output logic           mod_ctl,
  output logic           div_out
);
  import dmp_pkg::*;

  logic           rst_s;
  logic           reload;
  logic [N_W-1:0] n_cnt, n_nxt;
  logic [A_W-1:0] a_cnt, a_nxt;
  phase_e         ph_q, ph_d;
  logic           div_q, div_d;

  dmp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk_fin),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  // Count of 1 marks the last period; 0 only occurs after reset
  assign reload = (n_cnt <= N_W'(1));

  dmp_down_cnt #(.W(N_W)) u_n_cnt (
    .clk      (clk_fin),
    .rst_n    (rst_s),
    .load     (reload),
    .load_val (n_val),
    .en       (1'b1),
    .cnt      (n_cnt),
    .cnt_nxt  (n_nxt)
  );

  dmp_down_cnt #(.W(A_W)) u_a_cnt (
    .clk      (clk_fin),
    .rst_n    (rst_s),
    .load     (reload),
    .load_val (a_val),
    .en       (1'b1),
    .cnt      (a_cnt),
    .cnt_nxt  (a_nxt)
  );

  // Outputs are registered from the counters' next values, so they change on the same edge
  always_comb begin
    ph_d  = (a_nxt == '0) ? PH_HIGH : PH_LOW;
    div_d = (n_nxt == N_W'(1));
  end

  always_ff @(posedge clk_fin or negedge rst_s) begin
    if (!rst_s) begin
      ph_q  <= PH_IDLE;
      div_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      div_q <= div_d;
    end
  end

  assign mod_ctl = (ph_q == PH_HIGH);
  assign div_out = div_q;

  // R4: a reload takes N from the port
  p_reload_n_r4: assert property (@(posedge clk_fin) disable iff (!rst_s)
    reload |=> (n_cnt == $past(n_val)));

  // R2: the first period of a cycle is high only when A was zero at the reload
  p_mod_start_r2: assert property (@(posedge clk_fin) disable iff (!rst_s)
    reload |=> (mod_ctl == ($past(a_val) == '0)));

  // R3: once high, the modulus line holds until the cycle ends
  p_mod_hold_r3: assert property (@(posedge clk_fin) disable iff (!rst_s)
    (mod_ctl && !reload) |=> mod_ctl);

  // R3: a spent A counter keeps the line high for the rest of the cycle
  p_a_spent_r3: assert property (@(posedge clk_fin) disable iff (!rst_s)
    (a_cnt == '0 && !reload) |=> mod_ctl);

  // R4: the divided pulse lasts one period for any legal N
  p_div_once_r4: assert property (@(posedge clk_fin) disable iff (!rst_s)
    (div_out && n_val > N_W'(1)) |=> !div_out);
endmodule

// File: tb/tb_dmp_divider_ctl.sv
module tb_dmp_divider_ctl;
  localparam int P      = 8;
  localparam int TOTAL  = 24;
  localparam int WD_MAX = 190000;

  logic       vco;
  logic       rst_n;
  logic       fin;
  logic [9:0] n_in;
  logic [6:0] a_in;
  logic       mod_ctl;
  logic       div_out;

  int nchk  = 0;
  int nfail = 0;
  int vc    = 0;
  int pc    = 0;
  int cur_mod = P + 1;
  int cycles = 0;

  bit started = 0, pend = 0;
  int cur_n, cur_a, nxt_n, nxt_a, periods, last_vc;

  dmp_divider_ctl dut (
    .clk_fin (fin),
    .rst_n   (rst_n),
    .n_val   (n_in),
    .a_val   (a_in),
    .mod_ctl (mod_ctl),
    .div_out (div_out)
  );

  initial vco = 1'b0;
  always #5 vco = ~vco;   // 100 MHz oscillator

  // Behavioural prescaler: P+1 while mod_ctl low, P while high; modulus taken at count start
  initial fin = 1'b0;
  always @(posedge vco) begin
    vc++;
    if (pc == 0) cur_mod = mod_ctl ? P : P + 1;
    if (pc == cur_mod - 1) begin
      pc  <= 0;
      fin <= 1'b1;
    end else begin
      pc  <= pc + 1;
      fin <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span_of(input int n, input int a);
    int lowp = (a < n) ? a : n;
    return lowp * (P + 1) + (n - lowp) * P;
  endfunction

  // Directed corner cases first, then random values within the legal range
  function automatic int pick_n(input int i);
    case (i)
      0: return 16;   1: return 16;   2: return 16;   3: return 20;
      4: return 1023; 5: return 1023; 6: return 17;
      default: return $urandom_range(16, 260);
    endcase
  endfunction

  function automatic int pick_a(input int i);
    case (i)
      0: return 0;    1: return 15;   2: return 16;   3: return 127;
      4: return 127;  5: return 0;    6: return 1;
      default: return $urandom_range(0, 127);
    endcase
  endfunction

  always @(negedge fin) begin
    if (rst_n) begin
      if (pend) begin
        if (started) begin
          // R5 / R7: oscillator periods in the finished cycle
          chk((vc - last_vc) == span_of(cur_n, cur_a), "R5", vc - last_vc, span_of(cur_n, cur_a));
          // R4: cycle length in input periods
          chk(periods == cur_n, "R4", periods, cur_n);
        end
        started = 1;
        last_vc = vc;
        cur_n   = nxt_n;
        cur_a   = nxt_a;
        periods = 0;
        pend    = 0;
      end
      if (started) begin
        if (periods < cur_a)
          chk(mod_ctl == 1'b0, "R2", int'(mod_ctl), 0);
        else
          chk(mod_ctl == 1'b1, "R3", int'(mod_ctl), 1);
        chk(div_out == (periods == cur_n - 1), "R4", int'(div_out), int'(periods == cur_n - 1));
      end
      periods++;
      if (div_out) begin
        pend = 1;
        if (started) cycles++;
        n_in  = 10'(pick_n(cycles));
        a_in  = 7'(pick_a(cycles));
        nxt_n = int'(n_in);
        nxt_a = int'(a_in);
      end else if (started && periods == 3) begin
        // R6: mid-cycle writes must not disturb the running cycle
        n_in = 10'($urandom_range(16, 1023));
        a_in = 7'($urandom_range(0, 127));
      end
    end
  end

  initial begin
    int seed_dummy;
    int wd;
    seed_dummy = $urandom(32'h1F2E3D);
    rst_n = 1'b0;
    n_in  = 10'd40;
    a_in  = 7'd5;
    nxt_n = 40;
    nxt_a = 5;
    for (int i = 0; i < 6; i++) begin
      @(negedge vco);
      // R1: outputs idle during reset
      chk(mod_ctl == 1'b0, "R1", int'(mod_ctl), 0);
      chk(div_out == 1'b0, "R1", int'(div_out), 0);
    end
    rst_n = 1'b1;
    wd = 0;
    while (cycles < TOTAL && wd < WD_MAX) begin
      @(posedge vco);
      wd++;
    end
    if (wd >= WD_MAX) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, TOTAL);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule